// File: doc/BRIEF.md
# Serial controller interrupt identification unit

This unit gathers the four interrupt causes of a 16550-style serial controller into one interrupt request and an identification byte that software reads to find out why it was interrupted. The causes are receiver line errors, received data (or a character timeout), an empty transmit holding register and a change on a modem status line. The receiver, transmitter and modem logic report their status as pulses or levels. The register file passes in the interrupt enable bits, the request-enable bit from modem control, the FIFO-enabled state and strobes for register reads and writes.

Line errors, transmit-empty events and modem changes are held in sticky pending flags. Each flag has its own clearing condition. The received-data and timeout causes are levels owned by the receive FIFO. A fixed priority picks the single cause reported in the identification byte. The request output and the byte are both registered, so each one shows the state left after the clock edge that sampled its inputs.

Top module: `uart_irq_id`

## Requirements
- R1: After reset, `irq_o` is 0 and `iir_o` reads 0x01.
- R2: A cause whose enable bit in `ier_i` is 0 (bit 0 received data/timeout, bit 1 transmit empty, bit 2 line status, bit 3 modem status) neither raises `irq_o` nor appears in `iir_o`. A sticky cause that is latched while masked is reported once its enable bit is set.
- R3: When several enabled causes are active, the reported cause is chosen in this order, highest first: line status, received data/timeout, transmit empty, modem status.
- R4: `iir_o[3:0]` reads 0x6 for line status, 0x4 for received data, 0xC for character timeout, 0x2 for transmit empty, 0x0 for modem status and 0x1 when nothing is pending. Bit 0 is 0 exactly when a cause is being reported.
- R5: A pulse on any bit of `rx_err_i` (overrun, parity, framing, break) sets the line status cause. A pulse on `lsr_rd_i` clears it.
- R6: The received-data cause follows `rx_avail_i` or `rx_tmo_i` as a level. The timeout code is reported whenever `rx_tmo_i` is 1.
- R7: Reading the identification byte (`iir_rd_i`) clears the transmit-empty cause only when `iir_o[3:0]` is 0x2 at that read. A read that returns another code leaves it pending.
- R8: A write to the holding register (`thr_wr_i`) clears the transmit-empty cause.
- R9: A pulse on any bit of `ms_delta_i` sets the modem status cause. A pulse on `msr_rd_i` clears it.
- R10: `iir_o[7:6]` reads 11 when `fifo_en_i` is 1 and 00 otherwise. `iir_o[5:4]` always read 00.
- R11: `irq_o` is 1 only while `irq_en_i` is 1 and some enabled cause is reported.
- R12: Both outputs are registered. An input change is visible after the next rising clock edge and not before it.
- R13: When a set and a clear for the same sticky cause arrive in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ier_i | input | 4 | Interrupt enable bits |
| irq_en_i | input | 1 | Request output enable from modem control |
| fifo_en_i | input | 1 | FIFOs enabled |
| rx_err_i | input | 4 | Error pulses: overrun, parity, framing, break |
| rx_avail_i | input | 1 | Received data at or above trigger (level) |
| rx_tmo_i | input | 1 | Character timeout (level) |
| thr_empty_i | input | 1 | Holding register became empty (pulse) |
| thr_wr_i | input | 1 | Holding register written (pulse) |
| ms_delta_i | input | 4 | Modem line change pulses |
| iir_rd_i | input | 1 | Identification byte read strobe |
| lsr_rd_i | input | 1 | Line status read strobe |
| msr_rd_i | input | 1 | Modem status read strobe |
| irq_o | output | 1 | Interrupt request |
| iir_o | output | 8 | Identification byte |

## Verification
Each cause is driven alone so that its code and its own clearing strobe are seen in isolation. Each error bit and a modem delta bit are pulsed in turn to show that any one of them is enough to set the cause. All four causes are then stacked and removed one at a time, which shows the priority order. In that stacked state, an identification read returns the received-data code, and the transmit-empty cause must survive that read. Masked causes, a gated request line, simultaneous set and clear, the FIFO flag bits and a probe taken before the clock edge separate the gating, set-wins and latency rules from the encoder.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef enum logic [3:0] {
    ID_MODEM   = 4'h0,
    ID_NONE    = 4'h1,
    ID_TXEMPTY = 4'h2,
    ID_RXDATA  = 4'h4,
    ID_LINE    = 4'h6,
    ID_RXTMO   = 4'hC
  } irq_id_e;

  localparam int unsigned IER_RX    = 0;
  localparam int unsigned IER_TX    = 1;
  localparam int unsigned IER_LINE  = 2;
  localparam int unsigned IER_MODEM = 3;
  localparam int unsigned IER_W     = 4;

  localparam int unsigned SRC_LINE  = 0;
  localparam int unsigned SRC_TX    = 1;
  localparam int unsigned SRC_MODEM = 2;
  localparam int unsigned NUM_STICKY = 3;
endpackage

// File: rtl/uart_irq_flag.sv
module uart_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_nxt_o
);
  logic pend_q;

  // set dominates a coincident clear
  assign pend_nxt_o = set_i | (pend_q & ~clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_nxt_o;
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [IER_W-1:0] ier_i,
  input  logic             line_i,
  input  logic             rx_avail_i,
  input  logic             rx_tmo_i,
  input  logic             tx_i,
  input  logic             modem_i,
  output irq_id_e          id_o,
  output logic             active_o
);
  always_comb begin
    id_o = ID_NONE;
    if (line_i && ier_i[IER_LINE])                       id_o = ID_LINE;
    else if (rx_tmo_i && ier_i[IER_RX])                  id_o = ID_RXTMO;
    else if (rx_avail_i && ier_i[IER_RX])                id_o = ID_RXDATA;
    else if (tx_i && ier_i[IER_TX])                      id_o = ID_TXEMPTY;
    else if (modem_i && ier_i[IER_MODEM])                id_o = ID_MODEM;
  end

  assign active_o = (id_o != ID_NONE);
endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
  import uart_irq_pkg::*;
#(
  parameter int unsigned ERR_W   = 4,
  parameter int unsigned DELTA_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [IER_W-1:0]   ier_i,
  input  logic               irq_en_i,
  input  logic               fifo_en_i,
  input  logic [ERR_W-1:0]   rx_err_i,
  input  logic               rx_avail_i,
  input  logic               rx_tmo_i,
  input  logic               thr_empty_i,
  input  logic               thr_wr_i,
  input  logic [DELTA_W-1:0] ms_delta_i,
  input  logic               iir_rd_i,
  input  logic               lsr_rd_i,
  input  logic               msr_rd_i,
  output logic               irq_o,
  output logic [7:0]         iir_o
);
  logic [NUM_STICKY-1:0] src_set, src_clr, pend_nxt;
  irq_id_e id_nxt;
  logic    active;
  logic    irq_q;
  logic [7:0] iir_q;

  assign src_set[SRC_LINE]  = |rx_err_i;
  assign src_clr[SRC_LINE]  = lsr_rd_i;
  assign src_set[SRC_TX]    = thr_empty_i;
  // read clears transmit-empty only when it is the code being returned
  assign src_clr[SRC_TX]    = thr_wr_i | (iir_rd_i && (iir_q[3:0] == ID_TXEMPTY));
  assign src_set[SRC_MODEM] = |ms_delta_i;
  assign src_clr[SRC_MODEM] = msr_rd_i;

  for (genvar g = 0; g < NUM_STICKY; g++) begin : g_flag
    uart_irq_flag i_flag (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .set_i      (src_set[g]),
      .clr_i      (src_clr[g]),
      .pend_nxt_o (pend_nxt[g])
    );
  end

  uart_irq_prio i_prio (
    .ier_i      (ier_i),
    .line_i     (pend_nxt[SRC_LINE]),
    .rx_avail_i (rx_avail_i),
    .rx_tmo_i   (rx_tmo_i),
    .tx_i       (pend_nxt[SRC_TX]),
    .modem_i    (pend_nxt[SRC_MODEM]),
    .id_o       (id_nxt),
    .active_o   (active)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      iir_q <= {4'h0, ID_NONE};
    end else begin
      irq_q <= active & irq_en_i;
      iir_q <= {{2{fifo_en_i}}, 2'b00, id_nxt};
    end
  end

  assign irq_o = irq_q;
  assign iir_o = iir_q;
endmodule

// File: rtl/uart_irq_id_chk.sv
module uart_irq_id_chk #(
  parameter int unsigned ERR_W   = 4,
  parameter int unsigned DELTA_W = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [3:0]         ier_i,
  input logic               irq_en_i,
  input logic               fifo_en_i,
  input logic [ERR_W-1:0]   rx_err_i,
  input logic               thr_empty_i,
  input logic [DELTA_W-1:0] ms_delta_i,
  input logic               iir_rd_i,
  input logic               msr_rd_i,
  input logic               irq_o,
  input logic [7:0]         iir_o
);
  a_r11_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(irq_en_i));

  a_r4_irq_has_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !iir_o[0]);

  a_r10_fifo_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (iir_o[7:6] == {2{$past(fifo_en_i)}} && iir_o[5:4] == 2'b00));

  a_r5_line_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rx_err_i && ier_i[2]) |=> (iir_o[3:0] == 4'h6));

  a_r7_tx_read_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iir_rd_i && iir_o[3:0] == 4'h2 && !thr_empty_i) |=> (iir_o[3:0] != 4'h2));

  a_r9_modem_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msr_rd_i && ms_delta_i == '0 && iir_o[3:0] == 4'h0) |=> (iir_o[3:0] != 4'h0));
endmodule

bind uart_irq_id uart_irq_id_chk #(.ERR_W(ERR_W), .DELTA_W(DELTA_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ier_i       (ier_i),
  .irq_en_i    (irq_en_i),
  .fifo_en_i   (fifo_en_i),
  .rx_err_i    (rx_err_i),
  .thr_empty_i (thr_empty_i),
  .ms_delta_i  (ms_delta_i),
  .iir_rd_i    (iir_rd_i),
  .msr_rd_i    (msr_rd_i),
  .irq_o       (irq_o),
  .iir_o       (iir_o)
);

// File: tb/test_uart_irq_id.sv
module test_uart_irq_id;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] ier_i = '0;
  logic       irq_en_i = 1'b0, fifo_en_i = 1'b0;
  logic [3:0] rx_err_i = '0;
  logic       rx_avail_i = 1'b0, rx_tmo_i = 1'b0;
  logic       thr_empty_i = 1'b0, thr_wr_i = 1'b0;
  logic [3:0] ms_delta_i = '0;
  logic       iir_rd_i = 1'b0, lsr_rd_i = 1'b0, msr_rd_i = 1'b0;
  logic       irq_o;
  logic [7:0] iir_o;

  int n_chk = 0, n_fail = 0;

  always #2 clk_i = ~clk_i;

  uart_irq_id i_uart_irq_id (.*);

  task automatic cyc();
    @(negedge clk_i);
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic chk_out(string req, logic irq, logic [7:0] iir);
    chk(req, {7'b0, irq_o}, {7'b0, irq});
    chk(req, iir_o, iir);
  endtask

  task automatic t_reset();
    chk_out("R1 reset", 1'b0, 8'h01);
  endtask

  task automatic t_line();
    for (int i = 0; i < 4; i++) begin
      rx_err_i = 4'b1 << i; cyc(); rx_err_i = '0;
      chk_out("R5 line set", 1'b1, 8'h06);
      lsr_rd_i = 1'b1; cyc(); lsr_rd_i = 1'b0;
      chk_out("R5 line clear", 1'b0, 8'h01);
    end
  endtask

  task automatic t_rx();
    rx_avail_i = 1'b1; cyc();
    chk_out("R6 rx data", 1'b1, 8'h04);
    rx_tmo_i = 1'b1; cyc();
    chk_out("R6 timeout R4", 1'b1, 8'h0C);
    rx_avail_i = 1'b0; rx_tmo_i = 1'b0; cyc();
    chk_out("R6 rx drop", 1'b0, 8'h01);
  endtask

  task automatic t_tx();
    thr_empty_i = 1'b1; cyc(); thr_empty_i = 1'b0;
    chk_out("R4 tx empty", 1'b1, 8'h02);
    iir_rd_i = 1'b1; cyc(); iir_rd_i = 1'b0;
    chk_out("R7 read clears tx", 1'b0, 8'h01);
    thr_empty_i = 1'b1; cyc(); thr_empty_i = 1'b0;
    thr_wr_i = 1'b1; cyc(); thr_wr_i = 1'b0;
    chk_out("R8 write clears tx", 1'b0, 8'h01);
  endtask

  task automatic t_modem();
    ms_delta_i = 4'b0010; cyc(); ms_delta_i = '0;
    chk_out("R9 modem set", 1'b1, 8'h00);
    msr_rd_i = 1'b1; cyc(); msr_rd_i = 1'b0;
    chk_out("R9 modem clear", 1'b0, 8'h01);
  endtask

  task automatic t_prio();
    ms_delta_i = 4'b1000; thr_empty_i = 1'b1; rx_avail_i = 1'b1; rx_err_i = 4'b0100;
    cyc(); ms_delta_i = '0; thr_empty_i = 1'b0; rx_err_i = '0;
    chk_out("R3 line first", 1'b1, 8'h06);
    lsr_rd_i = 1'b1; cyc(); lsr_rd_i = 1'b0;
    chk_out("R3 rx second", 1'b1, 8'h04);
    iir_rd_i = 1'b1; cyc(); iir_rd_i = 1'b0;
    rx_avail_i = 1'b0; cyc();
    chk_out("R7 tx kept, R3 tx third", 1'b1, 8'h02);
    iir_rd_i = 1'b1; cyc(); iir_rd_i = 1'b0;
    chk_out("R3 modem last", 1'b1, 8'h00);
    msr_rd_i = 1'b1; cyc(); msr_rd_i = 1'b0;
    chk_out("R3 all clear", 1'b0, 8'h01);
  endtask

  task automatic t_mask();
    ier_i = 4'b0000;
    rx_err_i = 4'b0001; rx_avail_i = 1'b1; cyc(); rx_err_i = '0;
    chk_out("R2 masked", 1'b0, 8'h01);
    ier_i = 4'b0100; cyc();
    chk_out("R2 latched while masked", 1'b1, 8'h06);
    lsr_rd_i = 1'b1; cyc(); lsr_rd_i = 1'b0;
    chk_out("R2 rx still masked", 1'b0, 8'h01);
    rx_avail_i = 1'b0; ier_i = 4'hF; cyc();
  endtask

  task automatic t_irq_en();
    irq_en_i = 1'b0; rx_avail_i = 1'b1; cyc();
    chk_out("R11 gated", 1'b0, 8'h04);
    irq_en_i = 1'b1; cyc();
    chk_out("R11 ungated", 1'b1, 8'h04);
    rx_avail_i = 1'b0; cyc();
  endtask

  task automatic t_fifo();
    fifo_en_i = 1'b1; cyc();
    chk_out("R10 fifo idle", 1'b0, 8'hC1);
    rx_tmo_i = 1'b1; cyc();
    chk_out("R10 fifo timeout", 1'b1, 8'hCC);
    rx_tmo_i = 1'b0; fifo_en_i = 1'b0; cyc();
    chk_out("R10 fifo off", 1'b0, 8'h01);
  endtask

  task automatic t_latency();
    rx_avail_i = 1'b1; #1;
    chk_out("R12 before edge", 1'b0, 8'h01);
    cyc();
    chk_out("R12 after edge", 1'b1, 8'h04);
    rx_avail_i = 1'b0; cyc();
  endtask

  task automatic t_set_wins();
    rx_err_i = 4'b1000; cyc();
    lsr_rd_i = 1'b1; cyc(); rx_err_i = '0; lsr_rd_i = 1'b0;
    chk_out("R13 line set wins", 1'b1, 8'h06);
    lsr_rd_i = 1'b1; cyc(); lsr_rd_i = 1'b0;
    chk_out("R13 line cleared", 1'b0, 8'h01);
    thr_empty_i = 1'b1; thr_wr_i = 1'b1; cyc(); thr_empty_i = 1'b0; thr_wr_i = 1'b0;
    chk_out("R13 tx set wins", 1'b1, 8'h02);
    thr_wr_i = 1'b1; cyc(); thr_wr_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    cyc(); cyc();
    t_reset();
    rst_ni = 1'b1; cyc();
    t_reset();
    ier_i = 4'hF; irq_en_i = 1'b1; cyc();
    t_line();
    t_rx();
    t_tx();
    t_modem();
    t_prio();
    t_mask();
    t_irq_en();
    t_fifo();
    t_latency();
    t_set_wins();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule